// File: doc/BRIEF.md
# Data Abort Fault Status Unit

This unit sits beside the memory pipeline of a processor core and records data aborts. In any cycle several fault sources may raise a strobe at once: a misaligned access, an external error seen during a table walk, a missing translation, a domain check failure, a permission failure, a failed lock operation, an imprecise external bus error and a data cache parity error. The unit picks the single most urgent of them, turns it into a 5-bit fault code and loads that code into the status word, together with the access domain, the faulting data address and the abort return link.

Each source also decides three things: whether the captured domain means anything, whether the captured address means anything, and whether the abort is precise. A precise abort returns to the faulting instruction's PC plus 8 and can be recovered. An imprecise abort returns to the next instruction's PC plus 4 and cannot. The unit holds what it captured until the next strobe or a synchronous reset.

A three-state machine records what kind of abort was captured last. `ST_IDLE` is the state after reset, when nothing has been captured yet. `ST_PRECISE` and `ST_IMPRECISE` record the kind of the last captured abort. The transitions are: from any state, a cycle with at least one strobe moves to `ST_PRECISE` if the winning source is precise and to `ST_IMPRECISE` otherwise. A cycle with no strobe keeps the current state. Reset returns the machine to `ST_IDLE`. The recoverable output is high only in `ST_PRECISE`.

Top module: `dafs_unit`

## Requirements
- R1: The strobe bit position sets the priority, and the lowest set bit wins: 0 misalignment, 1 external error on table walk, 2 missing translation, 3 domain failure, 4 permission failure, 5 lock failure, 6 imprecise external error, 7 cache parity error.
- R2: Sources with a fixed code encode as follows: misalignment 0b00011, lock failure 0b10100, imprecise external error 0b10110, cache parity error 0b11000.
- R3: The sub-kind bit `flt_fine[i]` selects between two codes. For the walk error, 0 (first level) gives 0b01100 and 1 (second level) gives 0b01110. For a missing translation, 0 (section) gives 0b00101 and 1 (page) gives 0b00111. For a domain failure, section gives 0b01001 and page gives 0b01011. For a permission failure, section gives 0b01101 and page gives 0b01111.
- R4: `stat_word` bit 10 carries code bit 4, bits 3:0 carry code bits 3:0, and bits 9:4 are always zero.
- R5: `dom_ok` is set, and `dom_q` is loaded from `acc_dom`, for a domain failure, a permission failure, a second-level walk error and a page translation fault. For any other winner, `dom_ok` is cleared and `dom_q` keeps its previous value.
- R6: `addr_ok` is set, and `addr_q` is loaded from `data_addr`, when the winner is one of sources 0 to 4. For sources 5 to 7, `addr_ok` is cleared and `addr_q` keeps its previous value.
- R7: For winners 0 to 5 (precise), `link_q` becomes `pc_in` + 8, computed modulo 2^AW, and `recov` is 1.
- R8: For winners 6 and 7 (imprecise), `link_q` becomes `pc_in` + 4, computed modulo 2^AW, and `recov` is 0.
- R9: All outputs change one clock edge after the strobe cycle. In a cycle with no strobe, every output holds its value.
- R10: Synchronous reset clears every output to zero and puts the state machine in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_req | input | 8 | Fault strobes; the bit position sets the priority |
| flt_fine | input | 8 | Per-source sub-kind: page or second level when 1 |
| data_addr | input | AW | Effective data address of the access |
| acc_dom | input | DW | Domain of the access |
| pc_in | input | AW | Faulting PC (precise) or next PC (imprecise) |
| stat_word | output | 11 | Fault status word |
| dom_q | output | DW | Captured domain |
| dom_ok | output | 1 | Captured domain is meaningful |
| addr_q | output | AW | Captured fault address |
| addr_ok | output | 1 | Captured address is meaningful |
| link_q | output | AW | Abort return link |
| recov | output | 1 | Last captured abort is recoverable |

## Verification
Every result is due exactly one rising edge after the cycle in which the strobes are driven. The status word, domain, address, link and their flags are all registered on that edge, and `recov` follows the state register updated on the same edge. The driver sets inputs at a falling edge and pushes the expected item after the next rising edge. The monitor pops and compares at the following falling edge, so each comparison lands on the single cycle when the result first becomes visible. Cycles with no strobe and a reset in the middle of the run go through the same queue, so values that are held and values that are cleared are checked with the same one-edge timing.

// File: rtl/dafs_pkg.sv
package dafs_pkg;

    localparam int NSRC   = 8;
    localparam int CODE_W = 5;
    localparam int STAT_W = 11;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PRECISE   = 2'd1,
        ST_IMPRECISE = 2'd2
    } dafs_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              dom_ok;
        logic              addr_ok;
        logic              precise;
    } dafs_info_t;

    // Per-source attributes: code, domain meaning, address meaning, precision
    function automatic dafs_info_t src_info(input int idx, input logic fine);
        dafs_info_t r;
        r = '0;
        case (idx)
            0: begin r.code = 5'b00011; r.addr_ok = 1'b1; r.precise = 1'b1; end
            1: begin
                r.code    = fine ? 5'b01110 : 5'b01100;
                r.dom_ok  = fine;
                r.addr_ok = 1'b1;
                r.precise = 1'b1;
            end
            2: begin
                r.code    = fine ? 5'b00111 : 5'b00101;
                r.dom_ok  = fine;
                r.addr_ok = 1'b1;
                r.precise = 1'b1;
            end
            3: begin
                r.code    = fine ? 5'b01011 : 5'b01001;
                r.dom_ok  = 1'b1;
                r.addr_ok = 1'b1;
                r.precise = 1'b1;
            end
            4: begin
                r.code    = fine ? 5'b01111 : 5'b01101;
                r.dom_ok  = 1'b1;
                r.addr_ok = 1'b1;
                r.precise = 1'b1;
            end
            5: begin r.code = 5'b10100; r.precise = 1'b1; end
            6: begin r.code = 5'b10110; end
            default: begin r.code = 5'b11000; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dafs_prio.sv
module dafs_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Lowest index wins
    assign grant[0] = req[0];
    for (genvar g = 1; g < N; g++) begin : g_grant
        assign grant[g] = req[g] & ~(|req[g-1:0]);
    end
    assign any = |req;
endmodule

// File: rtl/dafs_encode.sv
module dafs_encode
    import dafs_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] grant,
    input  logic [N-1:0] fine,
    output dafs_info_t   info
);
    dafs_info_t per_src [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        assign per_src[g] = grant[g] ? src_info(g, fine[g]) : '0;
    end

    always_comb begin
        info = '0;
        for (int i = 0; i < N; i++) begin
            info = dafs_info_t'(info | per_src[i]);
        end
    end
endmodule

// File: rtl/dafs_unit.sv
module dafs_unit
    import dafs_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   flt_req,
    input  logic [NSRC-1:0]   flt_fine,
    input  logic [AW-1:0]     data_addr,
    input  logic [DW-1:0]     acc_dom,
    input  logic [AW-1:0]     pc_in,
    output logic [STAT_W-1:0] stat_word,
    output logic [DW-1:0]     dom_q,
    output logic              dom_ok,
    output logic [AW-1:0]     addr_q,
    output logic              addr_ok,
    output logic [AW-1:0]     link_q,
    output logic              recov
);
    localparam logic [AW-1:0] OFS_PRECISE   = AW'(8);
    localparam logic [AW-1:0] OFS_IMPRECISE = AW'(4);

    logic [NSRC-1:0]   grant;
    logic              any_req;
    dafs_info_t        info;
    dafs_state_e       state_q, state_d;
    logic [STAT_W-1:0] stat_d;

    dafs_prio #(.N(NSRC)) prio_i (
        .req   (flt_req),
        .grant (grant),
        .any   (any_req)
    );

    dafs_encode #(.N(NSRC)) enc_i (
        .grant (grant),
        .fine  (flt_fine),
        .info  (info)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) state_d = info.precise ? ST_PRECISE : ST_IMPRECISE;
            end
            ST_PRECISE: begin
                if (any_req && !info.precise) state_d = ST_IMPRECISE;
            end
            ST_IMPRECISE: begin
                if (any_req && info.precise) state_d = ST_PRECISE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        stat_d      = '0;
        stat_d[10]  = info.code[4];
        stat_d[3:0] = info.code[3:0];
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_word <= '0;
            dom_q     <= '0;
            dom_ok    <= 1'b0;
            addr_q    <= '0;
            addr_ok   <= 1'b0;
            link_q    <= '0;
        end else if (any_req) begin
            stat_word <= stat_d;
            dom_ok    <= info.dom_ok;
            addr_ok   <= info.addr_ok;
            if (info.dom_ok)  dom_q  <= acc_dom;
            if (info.addr_ok) addr_q <= data_addr;
            link_q <= pc_in + (info.precise ? OFS_PRECISE : OFS_IMPRECISE);
        end
    end

    assign recov = (state_q == ST_PRECISE);

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~flt_req) == '0)); // R1
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(|flt_req) |=> $stable(stat_word) && $stable(link_q) && $stable(dom_q) && $stable(addr_q)); // R9
    AST_DOM_CODE: assert property (@(posedge clk) disable iff (rst)
        dom_ok |-> (!stat_word[10] && stat_word[3:0] inside {4'hE, 4'h7, 4'h9, 4'hB, 4'hD, 4'hF})); // R5
    AST_ADDR_CODE: assert property (@(posedge clk) disable iff (rst)
        addr_ok |-> !stat_word[10]); // R6
    AST_RECOV_CODE: assert property (@(posedge clk) disable iff (rst)
        recov |-> (!stat_word[10] || stat_word[3:0] == 4'h4)); // R7
    AST_IMPREC_CODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IMPRECISE) |-> (stat_word[10] && !recov && !addr_ok)); // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        any_req |=> stat_word[9:4] == '0); // R4
endmodule

// File: tb/dafs_unit_tb_top.sv
module dafs_unit_tb_top;
    localparam int AW = 32;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    flt_req = '0;
    logic [7:0]    flt_fine = '0;
    logic [AW-1:0] data_addr = '0;
    logic [DW-1:0] acc_dom = '0;
    logic [AW-1:0] pc_in = '0;
    logic [10:0]   stat_word;
    logic [DW-1:0] dom_q;
    logic          dom_ok;
    logic [AW-1:0] addr_q;
    logic          addr_ok;
    logic [AW-1:0] link_q;
    logic          recov;

    dafs_unit #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .flt_req(flt_req), .flt_fine(flt_fine),
        .data_addr(data_addr), .acc_dom(acc_dom), .pc_in(pc_in),
        .stat_word(stat_word), .dom_q(dom_q), .dom_ok(dom_ok),
        .addr_q(addr_q), .addr_ok(addr_ok), .link_q(link_q), .recov(recov)
    );

    always #10 clk = ~clk; // 50 MHz

    typedef struct {
        logic [10:0]   stat;
        logic [DW-1:0] dom;
        logic          dom_ok;
        logic [AW-1:0] addr;
        logic          addr_ok;
        logic [AW-1:0] link;
        logic          recov;
        string         tag;
    } exp_t;

    exp_t q[$];
    exp_t m;           // model of the registered outputs
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic model_clear();
        m.stat = '0; m.dom = '0; m.dom_ok = 0; m.addr = '0;
        m.addr_ok = 0; m.link = '0; m.recov = 0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; flt_req = '0;
        @(posedge clk);
        model_clear();
        m.tag = tag;
        q.push_back(m);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Expected results from the requirement table
    task automatic apply(input logic [7:0] rq, input logic [7:0] fn,
                         input logic [AW-1:0] ad, input logic [DW-1:0] dm,
                         input logic [AW-1:0] pc, input string tag);
        int w;
        logic [4:0] c;
        logic dv, av, pr;
        @(negedge clk);
        flt_req = rq; flt_fine = fn; data_addr = ad; acc_dom = dm; pc_in = pc;
        @(posedge clk);
        w = -1;
        for (int i = 7; i >= 0; i--) if (rq[i]) w = i;
        if (w >= 0) begin
            dv = 0; av = (w <= 4); pr = (w <= 5);
            case (w)
                0: c = 5'b00011;
                1: begin c = fn[1] ? 5'b01110 : 5'b01100; dv = fn[1]; end
                2: begin c = fn[2] ? 5'b00111 : 5'b00101; dv = fn[2]; end
                3: begin c = fn[3] ? 5'b01011 : 5'b01001; dv = 1; end
                4: begin c = fn[4] ? 5'b01111 : 5'b01101; dv = 1; end
                5: c = 5'b10100;
                6: c = 5'b10110;
                default: c = 5'b11000;
            endcase
            m.stat = {c[4], 6'b0, c[3:0]};
            m.dom_ok = dv; if (dv) m.dom = dm;
            m.addr_ok = av; if (av) m.addr = ad;
            m.link = pr ? pc + 32'd8 : pc + 32'd4;
            m.recov = pr;
        end
        m.tag = tag;
        q.push_back(m);
    endtask

    task automatic cmp(input string tag, input string fld,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    // Monitor: compares one item per falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                cmp(e.tag, "stat", AW'(stat_word), AW'(e.stat));
                cmp(e.tag, "dom", AW'(dom_q), AW'(e.dom));
                cmp(e.tag, "dom_ok", AW'(dom_ok), AW'(e.dom_ok));
                cmp(e.tag, "addr", addr_q, e.addr);
                cmp(e.tag, "addr_ok", AW'(addr_ok), AW'(e.addr_ok));
                cmp(e.tag, "link", link_q, e.link);
                cmp(e.tag, "recov", AW'(recov), AW'(e.recov));
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset("R10 reset state");
        // R2 fixed codes
        apply(8'h01, 8'h00, 32'h1000_0003, 4'h5, 32'h0000_0100, "R2 misalign");
        apply(8'h20, 8'h00, 32'hAAAA_0000, 4'h9, 32'h0000_0200, "R2 R4 R6 lock");
        apply(8'h40, 8'h00, 32'hBBBB_0000, 4'h3, 32'h0000_0300, "R2 R8 imprecise");
        apply(8'h80, 8'h00, 32'hCCCC_0000, 4'h1, 32'h0000_0400, "R2 R8 parity");
        // R3 sub-kinds and R5 domain meaning
        apply(8'h02, 8'h00, 32'h2000_0000, 4'h7, 32'h0000_0500, "R3 R5 walk first level");
        apply(8'h02, 8'h02, 32'h2000_0010, 4'h6, 32'h0000_0504, "R3 R5 walk second level");
        apply(8'h04, 8'h00, 32'h3000_0000, 4'hA, 32'h0000_0600, "R3 R5 translation section");
        apply(8'h04, 8'h04, 32'h3000_0020, 4'hB, 32'h0000_0604, "R3 R5 translation page");
        apply(8'h08, 8'h00, 32'h4000_0000, 4'hC, 32'h0000_0700, "R3 R5 domain section");
        apply(8'h08, 8'h08, 32'h4000_0040, 4'hD, 32'h0000_0704, "R3 R5 domain page");
        apply(8'h10, 8'h00, 32'h5000_0000, 4'hE, 32'h0000_0800, "R3 R5 permission section");
        apply(8'h10, 8'h10, 32'h5000_0080, 4'hF, 32'h0000_0804, "R3 R5 permission page");
        // R1 priority sweep: all bits at or above i raised
        for (int i = 0; i < 8; i++) begin
            apply(8'hFF << i, 8'hFF, 32'h6000_0000 + 32'(i), 4'(i), 32'h0000_1000 + 32'(i * 16),
                  "R1 priority sweep");
        end
        apply(8'hC0, 8'h00, 32'h7000_0000, 4'h2, 32'h0000_2000, "R1 imprecise over parity");
        // R9 hold with no strobe
        apply(8'h00, 8'hFF, 32'hDEAD_BEEF, 4'h8, 32'h0000_3000, "R9 quiet hold");
        apply(8'h00, 8'h00, 32'h1234_5678, 4'h4, 32'h0000_4000, "R9 quiet hold");
        // R7 / R8 link wrap
        apply(8'h08, 8'h00, 32'h8000_0000, 4'h1, 32'hFFFF_FFFC, "R7 link wrap");
        apply(8'h40, 8'h00, 32'h8000_0004, 4'h1, 32'hFFFF_FFFE, "R8 link wrap");
        apply(8'h01, 8'h00, 32'h9000_0001, 4'h1, 32'h0000_5000, "R7 recover after imprecise");
        do_reset("R10 reset mid run");
        apply(8'h00, 8'h00, 32'h0, 4'h0, 32'h0, "R9 R10 idle after reset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule